// File: doc/BRIEF.md
# Ping-Pong Frame Fetch Sequencer

This block issues read bursts for a display pipeline that streams pixels out of one of two memory windows. Each window is set by a base and a ceiling word address, and both ends are inclusive. When ping-pong operation is on, the sequencer walks window 0 and then window 1, and keeps alternating. Each time a window is fully requested it emits that window's own end-of-frame pulse. Software uses that pulse to point the idle window at a fresh image.

Before pixel streaming starts, the block can fetch a colour-lookup table. That table is read from window 0's range and its completion is flagged by a separate pulse. The table phase can be followed by pixel streaming, run alone, or skipped. Requests leave on a valid/ready port that carries a start address and a word count. The memory, the pixel FIFO and the display timing sit outside this block.

Top module: `pingpong_fetch_seq`

## Requirements
- R1: `burstCode` sets the burst size: 0→1, 1→2, 2→4, 3→8, 4→16 words; codes 5, 6 and 7 also give 16 words.
- R2: A pass requests contiguous bursts starting at the window base and ending exactly at the ceiling, inclusive (ceiling ≥ base is required). Every burst except the last is full size. The last burst is cut short so that no word above the ceiling is requested.
- R3: While `dualEn` is 1, data passes alternate window 0, window 1, window 0 and so on, starting with window 0. The end of a window-0 pass pulses `eof0` and the end of a window-1 pass pulses `eof1`.
- R4: `dualEn` is sampled when a data pass completes. If it is 0 at that point, the next data pass uses window 0, so window 0 repeats and only `eof0` pulses.
- R5: `loadMode` is captured at `start`. Code 0 runs a table pass and then continuous data passes. Code 1 runs one table pass and then goes idle with no further requests. Codes 2 and 3 run data passes only.
- R6: The table pass covers `base0` to `ceil0` and ends with a one-cycle `palDone` pulse. The data phase after it begins with window 0.
- R7: A window's base and ceiling are captured when its pass begins. Writes made during the pass do not change it, and they take effect the next time that window is used.
- R8: Each completion pulse lasts one cycle, in the cycle after the final burst of the pass is accepted. In that same cycle the first request of the following pass is already presented. At most one of `eof0`, `eof1` and `palDone` is high at a time.
- R9: A request held while `reqReady` is 0 keeps `reqValid`, `reqAddr` and `reqLen` unchanged.
- R10: After reset there is no request and no pulse. `start` is only acted on when idle: the first request appears in the cycle after `start` is sampled, and `start` is ignored during a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when idle |
| dualEn | input | 1 | Alternate between both windows |
| loadMode | input | 2 | 0 table+data, 1 table only, 2/3 data only |
| burstCode | input | 3 | Burst size code |
| base0 | input | ADDR_W | Window 0 first word |
| ceil0 | input | ADDR_W | Window 0 last word |
| base1 | input | ADDR_W | Window 1 first word |
| ceil1 | input | ADDR_W | Window 1 last word |
| reqReady | input | 1 | Memory accepts the presented request |
| reqValid | output | 1 | Request presented |
| reqAddr | output | ADDR_W | Burst start word address |
| reqLen | output | MAX_LOG+1 | Burst length in words |
| eof0 | output | 1 | Window 0 pass complete |
| eof1 | output | 1 | Window 1 pass complete |
| palDone | output | 1 | Table pass complete |

## Verification
The first request of a sequence is due one cycle after `start` is sampled. Each following burst is due in the cycle after the previous one is accepted. A completion pulse is due exactly one cycle after the final burst's acceptance, and it coincides with the next pass's first request. The bench changes `reqReady` and samples every output on the falling clock edge. It tracks the expected address of each burst arithmetically, counting one accepted burst per falling edge where valid and ready are both seen. It lowers `reqReady` in the pulse cycle, so no handshake can happen there unobserved.

// File: rtl/pp_fetch_pkg.sv
package pp_fetch_pkg;

  typedef enum logic [1:0] {
    LM_TABLE_DATA = 2'd0,
    LM_TABLE_ONLY = 2'd1,
    LM_DATA       = 2'd2,
    LM_DATA_ALT   = 2'd3
  } load_mode_e;

  typedef struct packed {
    logic load;    // capture a window into the working registers
    logic pickB1;  // window 1 instead of window 0 on load
    logic step;    // advance past the accepted burst
  } fetch_strobe_t;

endpackage

// File: rtl/pp_fetch_path.sv
module pp_fetch_path
  import pp_fetch_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LOG = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  fetch_strobe_t       stb,
  input  logic                active,
  input  logic [2:0]          burstCode,
  input  logic [ADDR_W-1:0]   base0,
  input  logic [ADDR_W-1:0]   ceil0,
  input  logic [ADDR_W-1:0]   base1,
  input  logic [ADDR_W-1:0]   ceil1,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [MAX_LOG:0]    reqLen,
  output logic                lastBurst
);
  localparam int LEN_W = MAX_LOG + 1;
  localparam int SPAN_W = ADDR_W + 1;

  logic [ADDR_W-1:0] curAddr, curCeil;
  logic [2:0]        effCode;
  logic [LEN_W-1:0]  burstWords;
  logic [SPAN_W-1:0] span;

  always_comb begin
    effCode    = (burstCode > 3'(MAX_LOG)) ? 3'(MAX_LOG) : burstCode;
    burstWords = LEN_W'(1) << effCode;
    span       = {1'b0, curCeil} - {1'b0, curAddr} + SPAN_W'(1);
    lastBurst  = span <= SPAN_W'(burstWords);
    reqLen     = lastBurst ? span[LEN_W-1:0] : burstWords;
    reqAddr    = curAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curCeil <= '0;
    end else if (stb.load) begin
      curAddr <= stb.pickB1 ? base1 : base0;
      curCeil <= stb.pickB1 ? ceil1 : ceil0;
    end else if (stb.step) begin
      curAddr <= curAddr + ADDR_W'(reqLen);
    end
  end

  // R1
  len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (reqLen != '0) && (reqLen <= burstWords));

  // R2
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> ({1'b0, reqAddr} + SPAN_W'(reqLen) - SPAN_W'(1)) <= {1'b0, curCeil});

endmodule

// File: rtl/pp_fetch_ctrl.sv
module pp_fetch_ctrl
  import pp_fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          dualEn,
  input  logic [1:0]    loadMode,
  input  logic          reqReady,
  input  logic          lastBurst,
  output fetch_strobe_t stb,
  output logic          reqValid,
  output logic          eof0,
  output logic          eof1,
  output logic          palDone
);
  logic       busy, tablePhase, curBuf;
  load_mode_e modeReg;
  logic       fire, passEnd, nextBuf, launch;

  always_comb begin
    launch  = !busy && start;
    fire    = busy && reqReady;
    passEnd = fire && lastBurst;
    nextBuf = dualEn && !curBuf;
    stb     = '0;
    if (launch) begin
      stb.load = 1'b1;
    end else if (fire && !lastBurst) begin
      stb.step = 1'b1;
    end else if (passEnd) begin
      if (tablePhase) begin
        stb.load = (modeReg != LM_TABLE_ONLY);
      end else begin
        stb.load   = 1'b1;
        stb.pickB1 = nextBuf;
      end
    end
    reqValid = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      tablePhase <= 1'b0;
      curBuf     <= 1'b0;
      modeReg    <= LM_DATA;
      eof0       <= 1'b0;
      eof1       <= 1'b0;
      palDone    <= 1'b0;
    end else begin
      eof0    <= 1'b0;
      eof1    <= 1'b0;
      palDone <= 1'b0;
      if (launch) begin
        busy       <= 1'b1;
        modeReg    <= load_mode_e'(loadMode);
        tablePhase <= (loadMode == LM_TABLE_DATA) || (loadMode == LM_TABLE_ONLY);
        curBuf     <= 1'b0;
      end else if (passEnd) begin
        if (tablePhase) begin
          palDone    <= 1'b1;
          tablePhase <= 1'b0;
          curBuf     <= 1'b0;
          if (modeReg == LM_TABLE_ONLY) busy <= 1'b0;
        end else begin
          eof0   <= !curBuf;
          eof1   <= curBuf;
          curBuf <= nextBuf;
        end
      end
    end
  end

  // R8
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eof0, eof1, palDone}));

  // R5
  table_only_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (palDone && modeReg == LM_TABLE_ONLY) |-> !reqValid);

  // R4
  single_no_eof1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (passEnd && !tablePhase && !dualEn) |=> !curBuf);

endmodule

// File: rtl/pingpong_fetch_seq.sv
module pingpong_fetch_seq
  import pp_fetch_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dualEn,
  input  logic [1:0]        loadMode,
  input  logic [2:0]        burstCode,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] ceil0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [ADDR_W-1:0] ceil1,
  input  logic              reqReady,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [MAX_LOG:0]  reqLen,
  output logic              eof0,
  output logic              eof1,
  output logic              palDone
);
  fetch_strobe_t stb;
  logic          lastBurst;

  pp_fetch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dualEn(dualEn),
    .loadMode(loadMode), .reqReady(reqReady), .lastBurst(lastBurst),
    .stb(stb), .reqValid(reqValid), .eof0(eof0), .eof1(eof1),
    .palDone(palDone)
  );

  pp_fetch_path #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .active(reqValid),
    .burstCode(burstCode), .base0(base0), .ceil0(ceil0),
    .base1(base1), .ceil1(ceil1), .reqAddr(reqAddr),
    .reqLen(reqLen), .lastBurst(lastBurst)
  );

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid && $stable(reqAddr) && $stable(reqLen));

  // R10
  idle_after_reset_chk: assert property (@(posedge clk)
    !rstN |=> !reqValid && !eof0 && !eof1 && !palDone);

endmodule

// File: tb/pingpong_fetch_seq_test.sv
module pingpong_fetch_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN, start, dualEn, reqReady;
  logic [1:0] loadMode;
  logic [2:0] burstCode;
  logic [AW-1:0] base0, ceil0, base1, ceil1;
  logic reqValid, eof0, eof1, palDone;
  logic [AW-1:0] reqAddr;
  logic [4:0] reqLen;

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_fetch_seq #(.ADDR_W(AW), .MAX_LOG(4)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dualEn(dualEn),
    .loadMode(loadMode), .burstCode(burstCode), .base0(base0),
    .ceil0(ceil0), .base1(base1), .ceil1(ceil1), .reqReady(reqReady),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqLen(reqLen),
    .eof0(eof0), .eof1(eof1), .palDone(palDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; start = 1'b0; reqReady = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // evt: 3'b100 eof0, 3'b010 eof1, 3'b001 table done
  task automatic runPass(input int b, input int c, input int bw,
                         input logic [2:0] evt, input bit stall, input string req);
    int a = b;
    bit heldPrev = 1'b0;
    int heldAddr = 0;
    while (a <= c) begin
      @(negedge clk);
      cyc++;
      reqReady = stall ? (cyc % 3 != 1) : 1'b1;
      if ({eof0, eof1, palDone} != 3'b000)
        check(1'b0, "R8", "pulse inside pass", int'({eof0, eof1, palDone}), 0);
      if (heldPrev)
        check(reqValid && int'(reqAddr) == heldAddr, "R9", "held addr",
              int'(reqAddr), heldAddr);
      heldPrev = reqValid && !reqReady;
      heldAddr = int'(reqAddr);
      if (reqValid && reqReady) begin
        int exp = (c - a + 1 < bw) ? (c - a + 1) : bw;
        check(int'(reqAddr) == a, req, "burst addr", int'(reqAddr), a);
        check(int'(reqLen) == exp, "R1", "burst len", int'(reqLen), exp);
        a += exp;
      end
    end
    @(negedge clk);
    reqReady = 1'b0;
    check({eof0, eof1, palDone} == evt, "R8", "completion pulse",
          int'({eof0, eof1, palDone}), int'(evt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; dualEn = 1'b0; reqReady = 1'b0;
    loadMode = 2'd2; burstCode = 3'd0;
    base0 = '0; ceil0 = '0; base1 = '0; ceil1 = '0;

    // R10 reset state
    doReset();
    repeat (3) @(negedge clk);
    check(!reqValid, "R10", "valid after reset", int'(reqValid), 0);
    check({eof0, eof1, palDone} == 3'b000, "R10", "pulses after reset",
          int'({eof0, eof1, palDone}), 0);

    // R4 single window repeats; R10 start held high is ignored mid-pass
    doReset();
    loadMode = 2'd2; burstCode = 3'd2; dualEn = 1'b0;
    base0 = 16'h0100; ceil0 = 16'h010A;
    @(negedge clk); start = 1'b1;
    for (int p = 0; p < 3; p++) runPass('h100, 'h10A, 4, 3'b100, 1'b0, "R4");

    // R3 alternation with stalls (R9)
    doReset();
    loadMode = 2'd2; burstCode = 3'd3; dualEn = 1'b1;
    base0 = 16'h0100; ceil0 = 16'h0112; base1 = 16'h0200; ceil1 = 16'h020F;
    pulseStart();
    for (int p = 0; p < 2; p++) begin
      runPass('h100, 'h112, 8, 3'b100, 1'b1, "R3");
      runPass('h200, 'h20F, 8, 3'b010, 1'b1, "R3");
    end

    // R7 window rewrite takes effect on next use only
    doReset();
    loadMode = 2'd2; burstCode = 3'd1; dualEn = 1'b1;
    base0 = 16'h0100; ceil0 = 16'h0104; base1 = 16'h0200; ceil1 = 16'h0202;
    pulseStart();
    base0 = 16'h0300; ceil0 = 16'h0305;
    runPass('h100, 'h104, 2, 3'b100, 1'b0, "R7");
    base1 = 16'h0400; ceil1 = 16'h0400;
    runPass('h200, 'h202, 2, 3'b010, 1'b0, "R7");
    runPass('h300, 'h305, 2, 3'b100, 1'b0, "R7");
    runPass('h400, 'h400, 2, 3'b010, 1'b0, "R7");

    // R5 R6 table-only then idle
    doReset();
    loadMode = 2'd1; burstCode = 3'd0; dualEn = 1'b1;
    base0 = 16'h0040; ceil0 = 16'h0042;
    pulseStart();
    loadMode = 2'd2;
    runPass('h40, 'h42, 1, 3'b001, 1'b0, "R6");
    check(!reqValid, "R5", "idle in pulse cycle", int'(reqValid), 0);
    reqReady = 1'b1;
    repeat (4) @(negedge clk);
    check(!reqValid, "R5", "stays idle", int'(reqValid), 0);
    reqReady = 1'b0;

    // R5 R6 table then data on window 0
    doReset();
    loadMode = 2'd0; burstCode = 3'd1; dualEn = 1'b1;
    base0 = 16'h0080; ceil0 = 16'h0084; base1 = 16'h0090; ceil1 = 16'h0091;
    pulseStart();
    runPass('h80, 'h84, 2, 3'b001, 1'b0, "R6");
    runPass('h80, 'h84, 2, 3'b100, 1'b0, "R5");
    runPass('h90, 'h91, 2, 3'b010, 1'b0, "R5");

    // R5 code 3 is data only
    doReset();
    loadMode = 2'd3; burstCode = 3'd2; dualEn = 1'b0;
    base0 = 16'h0500; ceil0 = 16'h0506;
    pulseStart();
    runPass('h500, 'h506, 4, 3'b100, 1'b0, "R5");

    // R1 burst code sweep over a 20-word window
    for (int code = 0; code < 8; code++) begin
      doReset();
      loadMode = 2'd2; burstCode = 3'(code); dualEn = 1'b0;
      base0 = 16'h1000; ceil0 = 16'h1013;
      pulseStart();
      runPass('h1000, 'h1013, 1 << ((code > 4) ? 4 : code), 3'b100, code[0], "R1");
    end

    // R2 exact multiple and single word window
    doReset();
    loadMode = 2'd2; burstCode = 3'd4; dualEn = 1'b1;
    base0 = 16'h2000; ceil0 = 16'h200F; base1 = 16'h2100; ceil1 = 16'h2100;
    pulseStart();
    runPass('h2000, 'h200F, 16, 3'b100, 1'b0, "R2");
    runPass('h2100, 'h2100, 16, 3'b010, 1'b0, "R2");

    // R4 dual enable dropped during a window-1 pass
    doReset();
    loadMode = 2'd2; burstCode = 3'd2; dualEn = 1'b1;
    base0 = 16'h0600; ceil0 = 16'h0605; base1 = 16'h0700; ceil1 = 16'h0703;
    pulseStart();
    runPass('h600, 'h605, 4, 3'b100, 1'b0, "R4");
    dualEn = 1'b0;
    runPass('h700, 'h703, 4, 3'b010, 1'b0, "R4");
    runPass('h600, 'h605, 4, 3'b100, 1'b0, "R4");
    runPass('h600, 'h605, 4, 3'b100, 1'b0, "R4");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule